// File: doc/BRIEF.md
# Mirrored-Scan Horizontal Start Pulse Generator

This block drives the horizontal shift registers of a delta-arranged LCD panel. Pixels on neighbouring lines sit one and a half pixel clocks apart. The horizontal start pulse therefore has to land on a half-clock grid, and its position depends on four things: the line parity, the scan direction, the vertical scan direction and the aspect ratio. The block has two output sets. Set A scans in the direction picked by the right/left select. Set B always scans the other way. This lets a mirrored panel and a non-mirrored panel run from the same timing.

Each line begins with a one-cycle strobe on `line_go`. On that clock edge the block captures the following inputs:
- the video-start count `vstart_pos`, which is the number of clocks from the strobe edge to video start;
- the parity flag;
- the direction selects;
- the aspect select.

A sequencer then counts clocks. It has three states:
- `S_IDLE` is entered on clear.
- `S_COUNT` is entered from any state when `line_go` is high.
- `S_HOLD` is entered from `S_COUNT` once both sets have launched.

`S_HOLD` and `S_IDLE` leave only on `line_go`. When a start offset has a half-clock fraction, that set's pulse and scan clocks are launched from the falling clock edge. Otherwise they are launched from the rising edge.

Top module: `mirror_hstart_gen`

## Requirements
- R1: While `clr_n` is low at a rising edge, every start pulse and scan clock output is 0 after that edge. None of them becomes active again until a `line_go` strobe has been taken.
- R2: Each set produces exactly one start pulse per line. The pulse lasts exactly one clock period, which is two half-clock steps.
- R3: Line group rule. Signal encodings: `line_odd`=1 means an odd line, `ud_down`=1 means down scan, `wide_sel`=1 means 16:9. A line is aligned when `line_odd` equals `ud_down`. With 16:9 and the strobe edge as time 0, the start pulse rises at video start minus the lead. The lead is 2 clocks on aligned lines. On non-aligned lines it is 3.5 clocks for right scan and 0.5 clocks for left scan.
- R4: With `wide_sel`=0 (4:3), the same three groups have leads of 5, 6.5 and 3.5 clocks.
- R5: Set A scans right when `rl_sel`=1 and left when `rl_sel`=0. Set B always uses the opposite direction. The up/down select and parity apply to both sets alike.
- R6: `xrl_out` is high exactly when `rl_sel` is low.
- R7: A lead with a .5 fraction launches the pulse on a falling clock edge. A whole lead launches it on a rising edge. The launch edge chosen for a line does not change while that line counts.
- R8: From its start pulse onward, a set's two scan clocks are complementary. `hck1` is high for the first clock period, and both clocks toggle every clock period.
- R9: After a clear, a set's scan clocks both stay low until that set's first start pulse.
- R10: `vstart_pos` must be at least 8, so that even the 6.5-clock lead falls after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/master clock |
| clr_n | input | 1 | Synchronous active-low clear |
| line_go | input | 1 | One-cycle line-start strobe |
| vstart_pos | input | CNT_W | Clocks from strobe edge to video start |
| line_odd | input | 1 | 1 = odd line |
| rl_sel | input | 1 | 1 = set A scans right |
| ud_down | input | 1 | 1 = down scan, 0 = up scan |
| wide_sel | input | 1 | 1 = 16:9, 0 = 4:3 |
| hst_a | output | 1 | Start pulse, set A |
| hck1_a | output | 1 | Scan clock phase 1, set A |
| hck2_a | output | 1 | Scan clock phase 2, set A |
| hst_b | output | 1 | Start pulse, set B |
| hck1_b | output | 1 | Scan clock phase 1, set B |
| hck2_b | output | 1 | Scan clock phase 2, set B |
| xrl_out | output | 1 | Inverted right/left select |

## Verification
The bench builds the block with its default `CNT_W` of 10. It drives video-start counts of 8, 10, 12 and 20. The value 8 is the smallest the requirements allow, and at that value the 6.5-clock lead launches on the first counted clock, which tests the lower boundary of the counter compare. All sixteen combinations of parity, right/left, up/down and aspect run at a count of 12. This covers every lead on both sets and both launch edges. The bench also includes a clear issued while the scan clocks are running, followed by a fresh line, to test the idle-low clocks after a clear.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COUNT,
        S_HOLD
    } seq_state_t;

    // Lead ahead of video start, in half pixel clocks.
    function automatic logic [3:0] lead_halves(
        input logic odd,
        input logic right,
        input logic down,
        input logic wide
    );
        if (odd == down)
            return wide ? 4'd4 : 4'd10;
        else if (right)
            return wide ? 4'd7 : 4'd13;
        else
            return wide ? 4'd1 : 4'd7;
    endfunction

endpackage

// File: rtl/mhs_pos_calc.sv
module mhs_pos_calc #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] vstart,
    input  logic             odd,
    input  logic             right,
    input  logic             down,
    input  logic             wide,
    output logic [CNT_W-1:0] rise,
    output logic             half
);
    import mhs_pkg::*;

    localparam int HW = CNT_W + 1;

    logic [HW-1:0] pos_h;

    // Launch position in half clocks, counted from the strobe edge.
    assign pos_h = {vstart, 1'b0} - HW'(lead_halves(odd, right, down, wide));
    assign rise  = pos_h[HW-1:1];
    assign half  = pos_h[0];

endmodule

// File: rtl/mhs_lane.sv
module mhs_lane #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             counting,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise,
    input  logic             half,
    output logic             hst,
    output logic             hck1,
    output logic             hck2
);
    logic fire;
    logic st_p, ck_p, run_p;
    logic st_n, ck_n, run_n;

    assign fire = counting && ((cnt + CNT_W'(1)) == rise);

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            st_p  <= 1'b0;
            ck_p  <= 1'b0;
            run_p <= 1'b0;
        end else begin
            st_p <= fire;
            if (fire) begin
                ck_p  <= 1'b1;
                run_p <= 1'b1;
            end else if (run_p) begin
                ck_p <= ~ck_p;
            end
        end
    end

    // Half-clock delayed copy for leads with a .5 fraction.
    always_ff @(negedge clk) begin
        st_n  <= st_p;
        ck_n  <= ck_p;
        run_n <= run_p;
    end

    assign hst  = half ? st_n : st_p;
    assign hck1 = half ? (run_n & ck_n)  : (run_p & ck_p);
    assign hck2 = half ? (run_n & ~ck_n) : (run_p & ~ck_p);

    assert_pulse_one_clock_R2: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(st_p) |=> !st_p);

    assert_start_phase_R8: assert property (@(posedge clk) disable iff (!clr_n)
        st_p |-> (ck_p && run_p));

    assert_toggle_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (run_p && !st_p && $past(run_p)) |-> (ck_p != $past(ck_p)));

    assert_clear_R1: assert property (@(posedge clk)
        !clr_n |=> (!st_p && !run_p));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!clr_n)
        (!run_p && !fire) |=> !run_p);

endmodule

// File: rtl/mirror_hstart_gen.sv
module mirror_hstart_gen #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             line_go,
    input  logic [CNT_W-1:0] vstart_pos,
    input  logic             line_odd,
    input  logic             rl_sel,
    input  logic             ud_down,
    input  logic             wide_sel,
    output logic             hst_a,
    output logic             hck1_a,
    output logic             hck2_a,
    output logic             hst_b,
    output logic             hck1_b,
    output logic             hck2_b,
    output logic             xrl_out
);
    import mhs_pkg::*;

    localparam int NSET = 2;

    seq_state_t state, nstate;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rise_c [NSET];
    logic [CNT_W-1:0] rise_q [NSET];
    logic [NSET-1:0]  half_c;
    logic [NSET-1:0]  half_q;
    logic [NSET-1:0]  hst_v, hck1_v, hck2_v;
    logic [CNT_W-1:0] last;
    logic             counting;

    assign counting = (state == S_COUNT);
    assign last     = (rise_q[0] > rise_q[1]) ? rise_q[0] : rise_q[1];

    genvar g;
    generate
        for (g = 0; g < NSET; g++) begin : g_set
            // Set 0 follows rl_sel, set 1 scans the other way.
            logic dir_right;
            assign dir_right = (g == 0) ? rl_sel : ~rl_sel;

            mhs_pos_calc #(.CNT_W(CNT_W)) u_calc (
                .vstart (vstart_pos),
                .odd    (line_odd),
                .right  (dir_right),
                .down   (ud_down),
                .wide   (wide_sel),
                .rise   (rise_c[g]),
                .half   (half_c[g])
            );

            mhs_lane #(.CNT_W(CNT_W)) u_lane (
                .clk      (clk),
                .clr_n    (clr_n),
                .counting (counting),
                .cnt      (cnt),
                .rise     (rise_q[g]),
                .half     (half_q[g]),
                .hst      (hst_v[g]),
                .hck1     (hck1_v[g]),
                .hck2     (hck2_v[g])
            );
        end
    endgenerate

    // Next-state logic.
    always_comb begin
        nstate = state;
        if (line_go) begin
            nstate = S_COUNT;
        end else begin
            unique case (state)
                S_IDLE:  nstate = S_IDLE;
                S_COUNT: if ((cnt + CNT_W'(1)) == last) nstate = S_HOLD;
                S_HOLD:  nstate = S_HOLD;
                default: nstate = S_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!clr_n)
            state <= S_IDLE;
        else
            state <= nstate;
    end

    // Counter and per-line captured positions.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt    <= '0;
            half_q <= '0;
            for (int i = 0; i < NSET; i++) rise_q[i] <= '0;
        end else if (line_go) begin
            cnt    <= '0;
            half_q <= half_c;
            for (int i = 0; i < NSET; i++) rise_q[i] <= rise_c[i];
        end else if (state == S_COUNT) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign hst_a   = hst_v[0];
    assign hck1_a  = hck1_v[0];
    assign hck2_a  = hck2_v[0];
    assign hst_b   = hst_v[1];
    assign hck1_b  = hck1_v[1];
    assign hck2_b  = hck2_v[1];
    assign xrl_out = ~rl_sel;

    assert_hold_until_strobe_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (state == S_HOLD && !line_go) |=> (state == S_HOLD));

    assert_edge_stable_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (state == S_COUNT && !line_go) |=> $stable(half_q));

    assert_idle_after_clear_R1: assert property (@(posedge clk)
        (!clr_n) |=> (state == S_IDLE));

endmodule

// File: tb/tb_mirror_hstart_gen.sv
module tb_mirror_hstart_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;

    logic             clk = 1'b0;
    logic             clr_n = 1'b0;
    logic             line_go = 1'b0;
    logic [CNT_W-1:0] vstart_pos = '0;
    logic             line_odd = 1'b0, rl_sel = 1'b0, ud_down = 1'b0, wide_sel = 1'b0;
    logic             hst_a, hck1_a, hck2_a, hst_b, hck1_b, hck2_b, xrl_out;

    int errs = 0;
    int checks = 0;
    bit fresh = 1'b1;

    mirror_hstart_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .clr_n(clr_n), .line_go(line_go), .vstart_pos(vstart_pos),
        .line_odd(line_odd), .rl_sel(rl_sel), .ud_down(ud_down), .wide_sel(wide_sel),
        .hst_a(hst_a), .hck1_a(hck1_a), .hck2_a(hck2_a),
        .hst_b(hst_b), .hck1_b(hck1_b), .hck2_b(hck2_b), .xrl_out(xrl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Lead in half clocks, from the offset table written in clocks.
    function automatic int lead_of(bit odd, bit right, bit down, bit wide);
        real c;
        bit aligned;
        aligned = (odd && down) || (!odd && !down);
        if (wide) c = aligned ? 2.0 : (right ? 3.5 : 0.5);
        else      c = aligned ? 5.0 : (right ? 6.5 : 3.5);
        return int'(c * 2.0);
    endfunction

    task automatic check_set(input int t, input int h, input string req,
                             input logic hs, input logic c1, input logic c2);
        logic e1;
        chk(req, "start pulse", hs, (t >= h) && (t < h + 2));
        if (t >= h) begin
            e1 = (((t - h) / 2) % 2) == 0;
            chk("R8", "hck1", c1, e1);
            chk("R8", "hck2", c2, !e1);
        end else if (fresh) begin
            chk("R9", "hck1 idle", c1, 1'b0);
            chk("R9", "hck2 idle", c2, 1'b0);
        end
    endtask

    task automatic run_line(input int v, input bit odd, input bit rl, input bit down,
                            input bit wide, input int ncyc);
        int ha, hb;
        string ra;
        @(posedge clk); #2;
        vstart_pos = CNT_W'(v);
        line_odd = odd; rl_sel = rl; ud_down = down; wide_sel = wide;
        line_go = 1'b1;
        @(posedge clk); #1;
        line_go = 1'b0;
        #2;
        ha = 2 * v - lead_of(odd, rl, down, wide);
        hb = 2 * v - lead_of(odd, !rl, down, wide);
        ra = wide ? "R3 set A" : "R4 set A";
        for (int t = 0; t < 2 * ncyc; t++) begin
            if (t > 0) begin
                if (t % 2 == 1) @(negedge clk);
                else            @(posedge clk);
                #3;
            end
            check_set(t, ha, ra, hst_a, hck1_a, hck2_a);
            check_set(t, hb, "R5 set B", hst_b, hck1_b, hck2_b);
            chk("R6", "xrl_out", xrl_out, !rl);
        end
        fresh = 1'b0;
    endtask

    task automatic check_all_low(input string req);
        chk(req, "hst_a", hst_a, 1'b0);
        chk(req, "hck1_a", hck1_a, 1'b0);
        chk(req, "hck2_a", hck2_a, 1'b0);
        chk(req, "hst_b", hst_b, 1'b0);
        chk(req, "hck1_b", hck1_b, 1'b0);
        chk(req, "hck2_b", hck2_b, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        check_all_low("R1");
        @(posedge clk); #2;
        clr_n = 1'b1;
        fresh = 1'b1;

        // All groups, both aspects, both edges (R3, R4, R5, R7, R10).
        for (int w = 0; w < 2; w++)
            for (int r = 0; r < 2; r++)
                for (int d = 0; d < 2; d++)
                    for (int o = 0; o < 2; o++)
                        run_line(12, bit'(o), bit'(r), bit'(d), bit'(w), 16);

        // Lower boundary of video start (R10): 6.5-clock lead lands on count 1.
        run_line(8, 1'b1, 1'b1, 1'b1, 1'b1, 12);
        run_line(8, 1'b0, 1'b1, 1'b1, 1'b0, 12);
        run_line(8, 1'b1, 1'b0, 1'b0, 1'b0, 12);

        // Clear while scan clocks run (R1).
        run_line(10, 1'b0, 1'b0, 1'b1, 1'b1, 14);
        @(posedge clk); #2;
        clr_n = 1'b0;
        @(posedge clk); #3;
        check_all_low("R1");
        @(posedge clk); #2;
        clr_n = 1'b1;
        repeat (4) begin
            @(posedge clk); #3;
            check_all_low("R1");
            @(negedge clk); #3;
            check_all_low("R1");
        end
        fresh = 1'b1;

        // Fresh line after clear (R9).
        run_line(20, 1'b0, 1'b1, 1'b0, 1'b0, 26);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule